// File: doc/BRIEF.md
# Split-section ripple binary counter

This block is a four-bit binary ripple counter that is cut into two independently clocked sections. The lower section is one toggle stage that divides its own clock by two. The upper section is a chain of toggle stages that divides a second clock by eight. Every stage switches on the falling edge of its clock. Inside the upper section, each stage is clocked by the output of the stage below it, so the bits settle one after another rather than all at once.

No wire inside the block joins the lower stage's output to the upper section's clock. The surrounding logic chooses how the block is used. Feeding the lower output back into the upper clock, with count pulses on the lower clock, gives a four-bit counter. Pulses on the upper clock alone give a three-bit counter. The lower stage can also serve as a separate divide-by-two.

A master clear empties all stages at once and without waiting for a clock. It acts only when both of its qualifier inputs are high, and while it acts it takes precedence over both clocks. Because the outputs ripple, they are meant to be read only after they have settled. The short intermediate codes that appear during a ripple are not used as strobes.

Top module: `split_ripple_counter`

## Requirements
- R1: While clr_a and clr_b are both high, every bit of q is 0, and releasing the clear does not by itself change q.
- R2: Each falling edge of clk_lo inverts q[0]. A rising edge of clk_lo leaves q unchanged.
- R3: Each falling edge of clk_hi advances the upper field q[3:1] by one as an unsigned binary number with q[1] as its least significant bit, wrapping from 7 to 0. This gives division by 2, 4 and 8 at q[1], q[2] and q[3].
- R4: Edges on clk_lo never change q[3:1], and edges on clk_hi never change q[0].
- R5: When clk_hi is driven from q[0] outside the block and pulses arrive on clk_lo, q read as an unsigned number with q[0] as its least significant bit equals the number of falling edges on clk_lo modulo 16.
- R6: The clear acts only when clr_a and clr_b are both high. With only one of them high, both sections keep counting normally.
- R7: Falling edges on either clock while the clear is active leave q at 0.
- R8: After the clear is released, the first falling edge on a section's clock moves that section from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lo | input | 1 | Falling-edge clock of the divide-by-two stage |
| clk_hi | input | 1 | Falling-edge clock of the upper ripple chain |
| clr_a | input | 1 | First qualifier of the asynchronous master clear, active high |
| clr_b | input | 1 | Second qualifier of the asynchronous master clear, active high |
| q | output | HI_STAGES+1 (4) | Stage outputs, q[0] from the lower stage and q[HI_STAGES:1] from the upper chain |

## Verification
The bench uses the default HI_STAGES of 3, so the whole 16-state space of the linked four-bit counter, and the 8-state space of the upper chain on its own, are swept completely, with more than one wrap of each. It builds the feedback wire from q[0] to clk_hi itself and switches it in only while the clear is active. This means it can check the separate-section mode, the linked mode and the single-qualifier clear cases against a modulo count kept in the bench. All of these checks are made on the same netlist.

// File: rtl/ripcnt_pkg.sv
package ripcnt_pkg;

  // Master clear qualification: both qualifiers must be asserted.
  function automatic logic clear_request(input logic qual_a, input logic qual_b);
    return qual_a & qual_b;
  endfunction

  // Next state of one toggle stage.
  function automatic logic toggled(input logic cur);
    return ~cur;
  endfunction

endpackage

// File: rtl/master_clear.sv
module master_clear
  import ripcnt_pkg::*;
(
  input  logic qual_a,
  input  logic qual_b,
  output logic clr
);

  assign clr = clear_request(qual_a, qual_b);

endmodule

// File: rtl/toggle_stage.sv
module toggle_stage
  import ripcnt_pkg::*;
(
  input  logic clk_n,
  input  logic clr,
  output logic q
);

  always_ff @(negedge clk_n or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= toggled(q);
  end

  // Assertion support: value held before the last edge, and a marker that
  // a clear happened since that edge.
  logic fresh;
  logic q_seen;

  always_ff @(negedge clk_n or posedge clr) begin
    if (clr) begin
      fresh  <= 1'b1;
      q_seen <= 1'b0;
    end else begin
      fresh  <= 1'b0;
      q_seen <= q;
    end
  end

  // R2: every falling edge with no clear in between inverts the stage.
  a_r2_toggle_each_fall: assert property (@(negedge clk_n) disable iff (clr)
    !fresh |-> (q != q_seen))
    else $error("stage did not toggle on falling edge");

  // R7: a clock edge during clear finds the stage empty.
  always @(negedge clk_n) begin
    if (clr) begin
      a_r7_clear_blocks_edge: assert (q == 1'b0)
        else $error("stage not held at zero under clear");
    end
  end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk_n,
  input  logic              clr,
  output logic [STAGES-1:0] count
);

  // Clock seen by each stage: the section clock for the first, the previous
  // stage output for the rest.
  logic [STAGES-1:0] stage_clk;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage_clk[k] = clk_n;
    end else begin : g_link
      assign stage_clk[k] = count[k-1];
    end

    toggle_stage u_stage (
      .clk_n (stage_clk[k]),
      .clr   (clr),
      .q     (count[k])
    );
  end

  // Assertion support for the whole chain.
  logic              chain_fresh;
  logic [STAGES-1:0] count_seen;

  always_ff @(negedge clk_n or posedge clr) begin
    if (clr) begin
      chain_fresh <= 1'b1;
      count_seen  <= '0;
    end else begin
      chain_fresh <= 1'b0;
      count_seen  <= count;
    end
  end

  // R3: once settled, the chain reads one more than before the last edge.
  a_r3_counts_up: assert property (@(negedge clk_n) disable iff (clr)
    !chain_fresh |-> (count == STAGES'(count_seen + 1'b1)))
    else $error("ripple chain did not advance by one");

endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter #(
  parameter int HI_STAGES = 3
) (
  input  logic               clk_lo,
  input  logic               clk_hi,
  input  logic               clr_a,
  input  logic               clr_b,
  output logic [HI_STAGES:0] q
);

  localparam int OUT_W = HI_STAGES + 1;

  logic                 clr_evt;
  logic                 lo_bit;
  logic [HI_STAGES-1:0] hi_bits;

  master_clear u_clear (
    .qual_a (clr_a),
    .qual_b (clr_b),
    .clr    (clr_evt)
  );

  ripple_chain #(.STAGES(1)) u_lo (
    .clk_n (clk_lo),
    .clr   (clr_evt),
    .count (lo_bit)
  );

  ripple_chain #(.STAGES(HI_STAGES)) u_hi (
    .clk_n (clk_hi),
    .clr   (clr_evt),
    .count (hi_bits)
  );

  assign q = {hi_bits, lo_bit};

  // R1: under master clear the whole output is zero at any clock edge.
  always @(negedge clk_lo) begin
    if (clr_evt) begin
      a_r1_clear_lo_edge: assert (q == OUT_W'(0))
        else $error("outputs not clear at clk_lo edge");
    end
  end

  always @(negedge clk_hi) begin
    if (clr_evt) begin
      a_r1_clear_hi_edge: assert (q == OUT_W'(0))
        else $error("outputs not clear at clk_hi edge");
    end
  end

endmodule

// File: tb/test_split_ripple_counter.sv
module test_split_ripple_counter;

  localparam int HI = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic lo_d = 1'b1;
  logic hi_d = 1'b1;
  logic ra   = 1'b1;
  logic rb   = 1'b1;
  logic link = 1'b0;
  logic clk_hi_w;
  logic [HI:0] q;

  // External wiring chosen by the bench: q[0] feeds clk_hi in linked mode.
  assign clk_hi_w = link ? q[0] : hi_d;

  split_ripple_counter #(.HI_STAGES(HI)) i_split_ripple_counter (
    .clk_lo (lo_d),
    .clk_hi (clk_hi_w),
    .clr_a  (ra),
    .clr_b  (rb),
    .q      (q)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic check(input string tag, input logic [HI:0] exp);
    @(negedge clk);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  task automatic pulse_lo();
    @(posedge clk); lo_d = 1'b0;
    @(posedge clk); lo_d = 1'b1;
  endtask

  task automatic pulse_hi();
    @(posedge clk); hi_d = 1'b0;
    @(posedge clk); hi_d = 1'b1;
  endtask

  initial begin
    logic [2:0] up;
    logic       lo;
    repeat (3) @(posedge clk);
    check("R1", 4'd0);

    // R7: clock edges under clear do nothing
    for (int i = 0; i < 3; i++) begin pulse_lo(); pulse_hi(); end
    check("R7", 4'd0);

    @(posedge clk); ra = 1'b0; rb = 1'b0;
    check("R1", 4'd0);

    // R2/R4: lower stage alone, upper must stay zero
    lo = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      pulse_lo();
      lo = ~lo;
      check("R2", {3'd0, lo});
    end

    // R2: falling edge toggles, following rising edge does not
    @(posedge clk); lo_d = 1'b0;
    check("R2", 4'b0001);
    @(posedge clk); lo_d = 1'b1;
    check("R2", 4'b0001);
    pulse_lo();
    lo = 1'b0;
    check("R4", 4'b0000);

    // R8 then R3: upper chain alone, q[0] must stay put
    pulse_hi();
    check("R8", {3'd1, lo});
    up = 3'd1;
    for (int n = 2; n <= 20; n++) begin
      pulse_hi();
      up = up + 3'd1;
      check("R3", {up, lo});
    end

    // R4: lower edge leaves upper field alone
    pulse_lo();
    lo = 1'b1;
    check("R4", {up, lo});

    // R6: a single qualifier does not clear
    @(posedge clk); ra = 1'b1;
    pulse_lo();
    lo = ~lo;
    check("R6", {up, lo});
    @(posedge clk); ra = 1'b0; rb = 1'b1;
    pulse_hi();
    up = up + 3'd1;
    check("R6", {up, lo});
    @(posedge clk); ra = 1'b1;
    check("R1", 4'd0);

    // Linked mode: set up the feedback wire while cleared
    @(posedge clk); hi_d = 1'b0;
    @(posedge clk); link = 1'b1;
    @(posedge clk); ra = 1'b0; rb = 1'b0;
    check("R1", 4'd0);

    for (int n = 1; n <= 40; n++) begin
      pulse_lo();
      check("R5", 4'(n % 16));
    end

    // R7 in linked mode from a non-zero value
    @(posedge clk); ra = 1'b1; rb = 1'b1;
    check("R1", 4'd0);
    pulse_lo(); pulse_lo();
    check("R7", 4'd0);

    // R8 in linked mode
    @(posedge clk); ra = 1'b0; rb = 1'b0;
    pulse_lo();
    check("R8", 4'd1);

    // R6 in linked mode: single qualifier, counting continues through a carry
    @(posedge clk); rb = 1'b1;
    pulse_lo();
    check("R6", 4'd2);
    pulse_lo();
    check("R6", 4'd3);
    pulse_lo();
    check("R6", 4'd4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule